// File: doc/BRIEF.md
# SPI Dual-Range Register Port

This block is an SPI mode-0 slave. It lets an external host read and write the register space of a radio transceiver over four pins. That space has two parts. The first is a short bank of 64 byte-wide registers. The second is a long bank, addressed by 10 bits, which holds the RF configuration registers and the transmit and receive packet buffers.

Each chip-select window opens with a command. The most significant bit of the first byte selects the command format:
- A short command fits in one byte and is followed by one data byte.
- A long command takes two bytes. Long transfers then keep stepping the address for as many data bytes as the host clocks, both for writes and for reads, so a packet buffer can be moved in one window.

On the core side the block drives a byte-wide register bus. The bus has an address, a one-cycle write strobe, write data, and a combinational read-data return. The address carries a range flag in its top bit, so one decoder behind the port can serve both banks. The SPI pins are resynchronised into the core clock, and both SCK edges are detected in that clock domain. The core clock must therefore run well above SCK.

Top module: `spi_regport`

## Requirements
- R1: A one-byte short command whose bit 7 is 0 and bit 0 is 1 writes the next byte to the short register named by bits 6:1. The write appears as one `reg_wr` pulse with `reg_addr` = {1'b0, 4'b0000, bits 6:1}.
- R2: A short command with bit 0 = 0 returns the short register's byte on `miso`, MSB first, during the following byte. The first bit is driven after the falling SCK edge that ends the command.
- R3: A two-byte long command has bit 15 = 1, a 10-bit address in bits 14:5, and the write flag in bit 4; bits 3:0 are ignored. With bit 4 = 1, the next byte is written to `reg_addr` = {1'b1, address}.
- R4: After a long write command, every further complete byte in the same window is written, each to the next consecutive address, with no limit on the count. Each byte gives exactly one `reg_wr` pulse.
- R5: After a long read command, successive bytes in the same window return the bytes at consecutive long addresses.
- R6: During a long burst, the address wraps from 0x3FF to 0x000.
- R7: Raising `cs_n` discards any partial byte and any half-received command. The next byte after `cs_n` falls again is decoded as a fresh command, and no write occurs while `cs_n` is high.
- R8: A short transaction ends after its data byte. Further bytes in the same window cause no write and do not move the address.
- R9: After reset, `reg_wr` and `miso` are low and `reg_addr` is zero.
- R10: `miso` is low while `cs_n` is high and while the command bytes are being clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, well above SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Host-to-port serial data |
| miso | output | 1 | Port-to-host serial data |
| reg_addr | output | 11 | Register bus address: bit 10 selects the long range, bits 9:0 give the address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, valid in the same cycle |

## Verification
The bench builds the port with the default of two synchroniser stages and drives SCK at one sixteenth of the core clock. That leaves several core cycles between an SCK edge and the next one, so the read-data fetch, the address step and the MISO update each land inside one SCK half period, as they would at full speed. Because the full 10-bit long range is kept, a burst that starts at 0x3FD crosses the wrap point within five bytes. Short and long accesses also reach distinct locations of the 2048-byte target model, so a decode that mixed up the two ranges would show.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHORT_AW = 6;
  localparam int LONG_AW  = 10;
  localparam int BUS_AW   = LONG_AW + 1;
  localparam int HI_W     = LONG_AW - 3;   // address bits carried by first long byte
  localparam int CNT_W    = $clog2(BYTE_W);

  // pin vector order inside the synchroniser
  localparam int PIN_SCK  = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_MOSI = 2;
  localparam int PIN_N    = 3;

  typedef enum logic [1:0] {
    ST_CMD0 = 2'd0,
    ST_CMD1 = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } port_state_e;
endpackage

// File: rtl/spi_front.sv
module spi_front
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam logic [PIN_N-1:0] PIN_IDLE = PIN_N'(1) << PIN_CS;

  logic [PIN_N-1:0] pins;
  logic [PIN_N-1:0] stg_q [SYNC_STAGES];
  logic             sck_prev_q;
  logic [PIN_N-1:0] pins_s;

  assign pins[PIN_SCK]  = sck;
  assign pins[PIN_CS]   = cs_n;
  assign pins[PIN_MOSI] = mosi;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic [PIN_N-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = pins;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= PIN_IDLE;
      else        stg_q[g] <= stg_d;
    end
  end

  assign pins_s = stg_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= pins_s[PIN_SCK];
  end

  assign cs_act   = !pins_s[PIN_CS];
  assign mosi_s   = pins_s[PIN_MOSI];
  assign sck_rise = pins_s[PIN_SCK] && !sck_prev_q;
  assign sck_fall = !pins_s[PIN_SCK] && sck_prev_q;
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [BUS_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte
);
  port_state_e       state_q, state_n;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [BYTE_W-2:0] rx_q, rx_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic              wflag_q, wflag_n;
  logic [BUS_AW-1:0] addr_q, addr_n;
  logic              wr_q, wr_n;
  logic [BYTE_W-1:0] wdata_q, wdata_n;
  logic              inc_q, inc_n;
  logic              load_q, load_n;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;

  assign rx_byte   = {rx_q, mosi_s};
  assign byte_done = cs_act && sck_rise && (bit_q == CNT_W'(BYTE_W-1));

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    rx_n    = rx_q;
    hi_n    = hi_q;
    wflag_n = wflag_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    wr_n    = 1'b0;
    inc_n   = 1'b0;
    load_n  = 1'b0;

    // deferred address step of a long burst, then refetch for reads
    if (inc_q) begin
      addr_n[LONG_AW-1:0] = addr_q[LONG_AW-1:0] + 1'b1;
      load_n              = !wflag_q;
    end

    if (!cs_act) begin
      state_n = ST_CMD0;
      bit_n   = '0;
    end else if (sck_rise) begin
      bit_n = bit_q + 1'b1;
      rx_n  = rx_byte[BYTE_W-2:0];
      if (byte_done) begin
        unique case (state_q)
          ST_CMD0: begin
            if (!rx_byte[BYTE_W-1]) begin
              addr_n  = {1'b0, {(LONG_AW-SHORT_AW){1'b0}}, rx_byte[SHORT_AW:1]};
              wflag_n = rx_byte[0];
              load_n  = !rx_byte[0];
              state_n = ST_DATA;
            end else begin
              hi_n    = rx_byte[HI_W-1:0];
              state_n = ST_CMD1;
            end
          end
          ST_CMD1: begin
            addr_n  = {1'b1, hi_q, rx_byte[BYTE_W-1:BYTE_W-3]};
            wflag_n = rx_byte[4];
            load_n  = !rx_byte[4];
            state_n = ST_DATA;
          end
          ST_DATA: begin
            if (wflag_q) begin
              wr_n    = 1'b1;
              wdata_n = rx_byte;
            end
            if (addr_q[BUS_AW-1]) inc_n   = 1'b1;
            else                  state_n = ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD0;
      bit_q   <= '0;
      rx_q    <= '0;
      hi_q    <= '0;
      wflag_q <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      inc_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      rx_q    <= rx_n;
      hi_q    <= hi_n;
      wflag_q <= wflag_n;
      addr_q  <= addr_n;
      wr_q    <= wr_n;
      wdata_q <= wdata_n;
      inc_q   <= inc_n;
      load_q  <= load_n;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata_q;
  assign tx_load   = load_q;
  assign tx_byte   = reg_rdata;

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q); // R4
  AST_LONG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && addr_q[BUS_AW-1]) |=>
      (addr_q[LONG_AW-1:0] == $past(addr_q[LONG_AW-1:0]) + LONG_AW'(1))); // R6
  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !addr_q[BUS_AW-1]) |=> $stable(addr_q)); // R8
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !wr_q); // R7
endmodule

// File: rtl/spi_miso_tx.sv
module spi_miso_tx
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso
);
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              miso_q, miso_n;

  always_comb begin
    tx_n   = tx_q;
    miso_n = miso_q;
    if (!cs_act) begin
      tx_n   = '0;
      miso_n = 1'b0;
    end else if (tx_load) begin
      tx_n = tx_byte;
    end else if (sck_fall) begin
      miso_n = tx_q[BYTE_W-1];
      tx_n   = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      tx_q   <= tx_n;
      miso_q <= miso_n;
    end
  end

  assign miso = miso_q;

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_q); // R10
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [BUS_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              cs_act, sck_rise, sck_fall, mosi_s;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  spi_cmd_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cs_act    (cs_act),
    .sck_rise  (sck_rise),
    .mosi_s    (mosi_s),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte)
  );

  spi_miso_tx i_miso (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cs_act   (cs_act),
    .sck_fall (sck_fall),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .miso     (miso)
  );
endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
  localparam int HALF = 8;        // core clocks per SCK half period
  localparam int MEM_N = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [10:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;

  logic [7:0]  mem     [MEM_N];   // target behind the bus
  logic [7:0]  exp_mem [MEM_N];   // bench expectation
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  spi_regport i_spi_regport (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic long_cmd(input logic [9:0] a, input logic wr);
    logic [7:0] r;
    xfer({1'b1, a[9:3]}, r);
    check("R10 miso low in long cmd byte 1", r, 8'h00);
    xfer({a[2:0], wr, 4'hA}, r);   // low nibble is don't-care (R3)
    check("R10 miso low in long cmd byte 2", r, 8'h00);
  endtask

  // {op, addr, data}: op 0 short write, 1 short read, 2 long write, 3 long read
  localparam logic [19:0] VEC [12] = '{
    {2'd0, 10'h005, 8'hA1}, {2'd1, 10'h005, 8'h00}, {2'd1, 10'h03F, 8'h00},
    {2'd2, 10'h200, 8'h3C}, {2'd3, 10'h200, 8'h00}, {2'd3, 10'h005, 8'h00},
    {2'd2, 10'h3FF, 8'h0F}, {2'd0, 10'h03F, 8'h77}, {2'd3, 10'h3FF, 8'h00},
    {2'd1, 10'h03F, 8'h00}, {2'd0, 10'h000, 8'hFF}, {2'd1, 10'h000, 8'h00}
  };

  initial begin
    logic [7:0]  r;
    logic [10:0] ba;
    int          w0;
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = 8'(i * 7 + 3);

    repeat (5) @(negedge clk);
    check("R9 reset reg_wr", reg_wr, 1'b0);
    check("R9 reset miso", miso, 1'b0);
    check("R9 reset reg_addr", reg_addr, 11'h000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 reg_wr after release", reg_wr, 1'b0);

    for (int v = 0; v < 12; v++) begin
      logic [1:0] op;
      logic [9:0] a;
      logic [7:0] d;
      {op, a, d} = VEC[v];
      w0 = wr_cnt;
      cs_on();
      case (op)
        2'd0: begin
          ba = {5'b0, a[5:0]};
          xfer({1'b0, a[5:0], 1'b1}, r);
          xfer(d, r);
          cs_off();
          exp_mem[ba] = d;
          check("R1 short write data", mem[ba], d);
          check("R1 one strobe per short write", wr_cnt - w0, 1);
        end
        2'd1: begin
          ba = {5'b0, a[5:0]};
          xfer({1'b0, a[5:0], 1'b0}, r);
          check("R10 miso low in short cmd", r, 8'h00);
          xfer(8'h00, r);
          cs_off();
          check("R2 short read data", r, exp_mem[ba]);
        end
        2'd2: begin
          ba = {1'b1, a};
          long_cmd(a, 1'b1);
          xfer(d, r);
          cs_off();
          exp_mem[ba] = d;
          check("R3 long write data", mem[ba], d);
          check("R3 one strobe per long write", wr_cnt - w0, 1);
        end
        default: begin
          ba = {1'b1, a};
          long_cmd(a, 1'b0);
          xfer(8'h00, r);
          cs_off();
          check("R5 long read data", r, exp_mem[ba]);
        end
      endcase
    end
    check("R10 miso low with cs_n high", miso, 1'b0);

    // R4 / R6: burst write across the wrap point
    w0 = wr_cnt;
    cs_on();
    long_cmd(10'h3FD, 1'b1);
    for (int k = 0; k < 5; k++) xfer(8'hC0 + 8'(k), r);
    cs_off();
    check("R4 burst strobe count", wr_cnt - w0, 5);
    for (int k = 0; k < 5; k++) begin
      ba = {1'b1, 10'(10'h3FD + k)};
      exp_mem[ba] = 8'hC0 + 8'(k);
      check("R4 R6 burst write data", mem[ba], exp_mem[ba]);
    end

    // R5 / R6: burst read across the wrap point
    cs_on();
    long_cmd(10'h3FE, 1'b0);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, r);
      check("R5 R6 burst read data", r, exp_mem[{1'b1, 10'(10'h3FE + k)}]);
    end
    cs_off();

    // R7: partial byte aborted by chip select
    w0 = wr_cnt;
    cs_on();
    xfer_bits(8'hFF, 5, r);
    cs_off();
    check("R7 no write from partial byte", wr_cnt - w0, 0);
    cs_on();
    xfer({1'b0, 6'h12, 1'b1}, r);
    xfer(8'h5C, r);
    cs_off();
    exp_mem[11'h012] = 8'h5C;
    check("R7 next byte decoded as command", mem[11'h012], 8'h5C);
    check("R7 single strobe after abort", wr_cnt - w0, 1);

    // R7: half-received long command dropped
    cs_on();
    xfer({1'b1, 7'h7F}, r);
    cs_off();
    cs_on();
    xfer({1'b0, 6'h05, 1'b0}, r);
    xfer(8'h00, r);
    cs_off();
    check("R7 short read after dropped long cmd", r, exp_mem[11'h005]);

    // R8: extra bytes after a short write are ignored
    w0 = wr_cnt;
    cs_on();
    xfer({1'b0, 6'h20, 1'b1}, r);
    xfer(8'h11, r);
    xfer(8'h22, r);
    xfer(8'h33, r);
    cs_off();
    exp_mem[11'h020] = 8'h11;
    check("R8 short write keeps first byte", mem[11'h020], 8'h11);
    check("R8 neighbour untouched", mem[11'h021], exp_mem[11'h021]);
    check("R8 single strobe", wr_cnt - w0, 1);
    cs_on();
    xfer({1'b0, 6'h21, 1'b0}, r);
    xfer(8'h00, r);
    xfer(8'h00, r);
    cs_off();
    check("R8 extra read byte returns zero", r, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule